// File: doc/BRIEF.md
# Interrupt enable and halt controller

This sequential controller owns the master interrupt enable of a small CPU core and its low-power halt state. The instruction decoder gives it one-cycle strobes: enable-interrupts, disable-interrupts, return-from-interrupt, halt, and an instruction-boundary strobe that marks the completion of an instruction. It also takes a single pending-interrupt level, which is the OR of all interrupt lines that are both requested and enabled.

From these inputs it produces four outputs. The first is the master enable itself. The second is a halted flag that stalls instruction fetch. The third is a one-cycle dispatch request that tells the core to enter a handler. The fourth is a one-cycle pulse that stops the program counter from advancing once, which reproduces the double fetch that follows a halt issued with interrupts disabled while one is already pending. Vector selection and stacking of the program counter belong to the core and are not part of this block. All outputs are registered, so each one reflects the inputs sampled on the previous clock edge.

Top module: `irq_gate_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, enable, halted, dispatch and hold are all 0, and no delayed enable is waiting.
- R2: A disable strobe makes the enable 0 in the next cycle. It also cancels a delayed enable that is still waiting, and it wins over an enable strobe in the same cycle.
- R3: After an enable strobe, the enable becomes 1 in the cycle after the first boundary strobe that arrives strictly later than the enable strobe. A boundary strobe in the same cycle as the enable strobe does not count.
- R4: A return-from-interrupt strobe makes the enable 1 in the next cycle, with no delay.
- R5: A cycle in which the controller is not halted, a boundary strobe is present, the enable is 1 and an interrupt is pending gives a dispatch pulse in the next cycle, with the enable 0 in that same cycle. This clearing takes priority over a return-from-interrupt strobe or a completing delayed enable in the same cycle.
- R6: A halt strobe with no interrupt pending sets halted in the next cycle. Halted stays 1 for as long as nothing is pending.
- R7: If an interrupt becomes pending while halted with the enable at 1, the next cycle shows halted 0, dispatch 1 and enable 0.
- R8: If an interrupt becomes pending while halted with the enable at 0, the next cycle shows halted 0, with no dispatch and the enable still 0.
- R9: A halt strobe with the enable at 0 and an interrupt already pending does not halt. Instead it gives a one-cycle hold pulse in the next cycle.
- R10: A halt strobe with the enable at 1 and an interrupt already pending gives neither halt nor hold. The dispatch then follows at the next boundary strobe, as in R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ei_stb | input | 1 | Enable-interrupts strobe (delayed effect) |
| di_stb | input | 1 | Disable-interrupts strobe |
| reti_stb | input | 1 | Return-from-interrupt strobe (immediate enable) |
| halt_stb | input | 1 | Halt instruction strobe |
| boundary | input | 1 | Instruction completed in this cycle |
| irq_pending | input | 1 | Some enabled interrupt is requested |
| ime | output | 1 | Master interrupt enable |
| halted | output | 1 | Core sleeping, fetch stalled |
| dispatch | output | 1 | One-cycle handler entry request |
| pc_hold | output | 1 | One-cycle suppression of the program counter increment |

## Verification
Several enable patterns are driven. One puts an enable strobe and a boundary strobe in the same cycle. Another places an idle gap before the boundary, and a third puts a disable strobe between the enable and the boundary. Together these separate an enable that waits for the following instruction from one that arms at once or survives cancellation. Halt is issued in all four combinations of enable state and pending state, which distinguishes sleep, wake with a handler, wake without one, and the hold pulse. A final case combines return-from-interrupt, a boundary strobe and a pending interrupt in one cycle, which shows whether dispatch correctly wins the enable.

// File: rtl/igc_pkg.sv
package igc_pkg;

    typedef struct packed {
        logic ei;
        logic di;
        logic reti;
        logic halt;
        logic boundary;
    } igc_strobe_t;

    typedef struct packed {
        logic halted;
        logic dispatch;
        logic hold;
    } igc_sleep_t;

endpackage

// File: rtl/igc_enable_unit.sv
module igc_enable_unit
    import igc_pkg::*;
#(
    parameter int EI_DELAY = 1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  igc_strobe_t stb,
    input  logic        take,
    output logic        ime_q
);
    localparam int CW = $clog2(EI_DELAY + 1);
    localparam logic [CW-1:0] LOAD = CW'(EI_DELAY);

    typedef struct packed {
        logic          ime;
        logic [CW-1:0] cnt;
    } en_state_t;

    en_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // delayed enable counts completed instructions
        if (stb.boundary && st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - 1'b1;
            if (st_q.cnt == CW'(1)) st_d.ime = 1'b1;
        end
        if (stb.reti) st_d.ime = 1'b1;
        if (take)     st_d.ime = 1'b0;
        if (stb.di) begin
            st_d.ime = 1'b0;
            st_d.cnt = '0;
        end else if (stb.ei) begin
            st_d.cnt = LOAD;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ime_q = st_q.ime;

    a_r2_di_clears: assert property (@(posedge clk) disable iff (!rst_n)
        stb.di |=> !ime_q);
    a_r4_reti_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (stb.reti && !stb.di && !take) |=> ime_q);
    a_r3_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ime_q) |-> $past(stb.boundary || stb.reti));

endmodule

// File: rtl/igc_sleep_unit.sv
module igc_sleep_unit
    import igc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  igc_strobe_t stb,
    input  logic        irq_pending,
    input  logic        ime_q,
    output logic        take,
    output igc_sleep_t  sl_q
);
    igc_sleep_t sl_d;

    always_comb begin
        take = ime_q && irq_pending && (sl_q.halted || stb.boundary);
        sl_d.dispatch = take;
        if (sl_q.halted) sl_d.halted = !irq_pending;
        else             sl_d.halted = stb.halt && !irq_pending;
        sl_d.hold = !sl_q.halted && stb.halt && irq_pending && !ime_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sl_q <= '0;
        else        sl_q <= sl_d;
    end

    a_r6_sleep_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (sl_q.halted && !irq_pending) |=> sl_q.halted);
    a_r7_wake: assert property (@(posedge clk) disable iff (!rst_n)
        (sl_q.halted && irq_pending) |=> !sl_q.halted);
    a_r9_hold_excl: assert property (@(posedge clk) disable iff (!rst_n)
        sl_q.hold |-> !sl_q.halted);

endmodule

// File: rtl/irq_gate_ctrl.sv
module irq_gate_ctrl
    import igc_pkg::*;
#(
    parameter int EI_DELAY = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ei_stb,
    input  logic di_stb,
    input  logic reti_stb,
    input  logic halt_stb,
    input  logic boundary,
    input  logic irq_pending,
    output logic ime,
    output logic halted,
    output logic dispatch,
    output logic pc_hold
);
    igc_strobe_t stb;
    igc_sleep_t  sl_q;
    logic        take;
    logic        ime_q;

    assign stb = '{ei: ei_stb, di: di_stb, reti: reti_stb,
                   halt: halt_stb, boundary: boundary};

    igc_enable_unit #(.EI_DELAY(EI_DELAY)) u_enable (
        .clk   (clk),
        .rst_n (rst_n),
        .stb   (stb),
        .take  (take),
        .ime_q (ime_q)
    );

    igc_sleep_unit u_sleep (
        .clk         (clk),
        .rst_n       (rst_n),
        .stb         (stb),
        .irq_pending (irq_pending),
        .ime_q       (ime_q),
        .take        (take),
        .sl_q        (sl_q)
    );

    assign ime      = ime_q;
    assign halted   = sl_q.halted;
    assign dispatch = sl_q.dispatch;
    assign pc_hold  = sl_q.hold;

    a_r5_dispatch_clears: assert property (@(posedge clk) disable iff (!rst_n)
        dispatch |-> !ime);

endmodule

// File: tb/irq_gate_ctrl_bench.sv
module irq_gate_ctrl_bench;
    localparam int EI_DELAY = 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ei_stb = 0, di_stb = 0, reti_stb = 0, halt_stb = 0, boundary = 0, irq_pending = 0;
    logic ime, halted, dispatch, pc_hold;

    always #5 clk = ~clk;

    irq_gate_ctrl #(.EI_DELAY(EI_DELAY)) u_irq_gate_ctrl (
        .clk(clk), .rst_n(rst_n), .ei_stb(ei_stb), .di_stb(di_stb),
        .reti_stb(reti_stb), .halt_stb(halt_stb), .boundary(boundary),
        .irq_pending(irq_pending), .ime(ime), .halted(halted),
        .dispatch(dispatch), .pc_hold(pc_hold)
    );

    typedef struct {
        logic [3:0] outs;   // ime, halted, dispatch, hold
        string      tag;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0;
    int   errors = 0;
    bit   done   = 0;

    // reference state built from the requirements
    bit m_ime = 0, m_halt = 0, m_disp = 0, m_hold = 0;
    int m_cnt = 0;

    task automatic step(input bit ei, di, reti, hlt, bnd, pend, input string tag);
        bit take, n_ime;
        int n_cnt;
        exp_t e;
        @(negedge clk);
        ei_stb = ei; di_stb = di; reti_stb = reti;
        halt_stb = hlt; boundary = bnd; irq_pending = pend;
        take  = m_ime && pend && (m_halt || bnd);
        n_ime = m_ime;
        n_cnt = m_cnt;
        if (bnd && m_cnt > 0) begin
            n_cnt = m_cnt - 1;
            if (n_cnt == 0) n_ime = 1;
        end
        if (reti) n_ime = 1;
        if (take) n_ime = 0;
        if (di) begin n_ime = 0; n_cnt = 0; end
        else if (ei) n_cnt = EI_DELAY;
        m_hold = !m_halt && hlt && pend && !m_ime;
        m_halt = m_halt ? !pend : (hlt && !pend);
        m_disp = take;
        m_ime  = n_ime;
        m_cnt  = n_cnt;
        e.outs = {m_ime, m_halt, m_disp, m_hold};
        e.tag  = tag;
        exp_q.push_back(e);
    endtask

    task automatic idle(input string tag);
        step(0, 0, 0, 0, 0, 0, tag);
    endtask

    // monitor: compares away from the active edge
    always @(posedge clk) begin
        #2;
        if (exp_q.size() > 0) begin
            exp_t e;
            logic [3:0] act;
            e   = exp_q.pop_front();
            act = {ime, halted, dispatch, pc_hold};
            checks++;
            if (act !== e.outs) begin
                errors++;
                $display("FAIL %s: ime/halted/dispatch/hold actual=%b expected=%b",
                         e.tag, act, e.outs);
            end
        end
    end

    initial begin
        #100000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if ({ime, halted, dispatch, pc_hold} !== 4'b0000) begin
            errors++;
            $display("FAIL R1: actual=%b expected=0000", {ime, halted, dispatch, pc_hold});
        end
        rst_n = 1'b1;
        idle("R1");
        idle("R1");

        // R4 immediate enable, R2 disable
        step(0, 0, 1, 0, 0, 0, "R4");
        step(0, 0, 0, 0, 1, 0, "R4");
        step(0, 1, 0, 0, 0, 0, "R2");
        idle("R2");

        // R3 same-cycle boundary ignored, gap, then boundary
        step(1, 0, 0, 0, 1, 0, "R3");
        idle("R3");
        step(0, 0, 0, 0, 1, 0, "R3");
        idle("R3");
        step(0, 1, 0, 0, 0, 0, "R2");

        // R2 cancel of waiting enable, and same-cycle enable+disable
        step(1, 0, 0, 0, 0, 0, "R2");
        step(0, 1, 0, 0, 0, 0, "R2");
        step(0, 0, 0, 0, 1, 0, "R2");
        step(1, 1, 0, 0, 0, 0, "R2");
        step(0, 0, 0, 0, 1, 0, "R2");
        idle("R2");

        // R5 dispatch needs boundary
        step(0, 0, 1, 0, 0, 0, "R5");
        step(0, 0, 0, 0, 0, 1, "R5");
        step(0, 0, 0, 0, 1, 1, "R5");
        idle("R5");

        // R6/R7 halt with enable set, wake with dispatch
        step(0, 0, 1, 0, 0, 0, "R7");
        step(0, 0, 0, 1, 0, 0, "R6");
        for (int i = 0; i < 4; i++) idle("R6");
        step(0, 0, 0, 0, 0, 1, "R7");
        idle("R7");

        // R8 halt with enable clear, wake without dispatch
        step(0, 0, 0, 1, 0, 0, "R6");
        idle("R8");
        step(0, 0, 0, 0, 0, 1, "R8");
        idle("R8");

        // R9 hold pulse
        step(0, 0, 0, 1, 0, 1, "R9");
        step(0, 0, 0, 0, 0, 1, "R9");
        idle("R9");

        // R10 halt with enable set and pending: no sleep, dispatch at boundary
        step(0, 0, 1, 0, 0, 0, "R10");
        step(0, 0, 0, 1, 0, 1, "R10");
        step(0, 0, 0, 0, 1, 1, "R10");
        idle("R10");

        // R5 priority: dispatch beats a same-cycle return-from-interrupt
        step(0, 0, 1, 0, 0, 0, "R5");
        step(0, 0, 1, 0, 1, 1, "R5");
        idle("R5");
        // R5 priority: dispatch beats a completing delayed enable
        step(1, 0, 0, 0, 0, 0, "R5");
        step(0, 0, 1, 0, 0, 0, "R5");
        step(0, 0, 0, 0, 1, 1, "R5");
        idle("R5");
        idle("R5");

        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule